// File: doc/BRIEF.md
# Queued SPI Master Controller

This block is an SPI master that works through a list of up to sixteen transfers on its own once a host has set it up. Three small memories hold the list: one word of outgoing data per entry, one word of incoming data per entry, and one command byte per entry. The command byte decides how long that transfer is, which peripheral selects are driven, how long to wait between select and first clock, how long to pause afterwards, and whether the selects stay asserted into the following entry. A host loads the memories and a handful of setup registers through a simple write/read port, sets the run bit, and later finds a completion flag raised.

Addresses on the host port split into four regions of sixteen words. Region 0 (0x00-0x0F) is the outgoing data memory and region 2 (0x20-0x2F) the command memory; both are write-only and read back as zero. Region 1 (0x10-0x1F) is the incoming data memory, read-only. Region 3 holds the setup registers: 0x30 run control (bits 3:0 first entry, 7:4 last entry, 8 loop, 9 run), 0x31 format (bits 4:0 programmed length, 15:8 half-period in system clocks), 0x32 delays (bits 7:0 post-transfer count, 15:8 select-to-clock count), 0x33 idle select levels (bits 3:0), and 0x34 status (bit 0 done; any write clears it). Reset values: format 0x0410, delays 0, idle levels 0xF, everything else 0. A zero half-period or zero delay count is treated as one clock.

The serial clock idles low; the controller puts each bit on the data output after a falling edge and captures the data input on each rising edge, most significant bit first. Each clock phase lasts the programmed half-period.

Top module: `qspi_master`

## Requirements
- R1: After reset the select outputs are 1111, the serial clock is 0, the data output is 1, the done flag is 0 and every incoming data entry reads 0.
- R2: A run starts at the first entry and advances one entry at a time, going from entry 15 to entry 0, up to and including the last entry; entries outside that span are not transferred and their incoming data stays unchanged.
- R3: Command bit 6 clear gives an 8-bit transfer; bit 6 set gives the programmed length (8 to 16, clamped into that range). The low n bits of the outgoing word are shifted out most significant first.
- R4: The n bits captured during an entry's transfer are stored right-aligned, upper bits zero, in the incoming memory at that entry's index.
- R5: During a transfer the select outputs 3..0 carry command bits 3..0.
- R6: Command bit 7 set keeps the selects at the entry's levels until the next entry drives its own; clear returns them to the idle levels at the end of the transfer.
- R7: With command bit 7 clear, the selects stay idle for the post delay plus one clock before the next entry asserts them; the post delay is 17 clocks when command bit 5 is clear and the programmed count when set.
- R8: The time from select assertion to the first rising serial clock equals the half-period when command bit 4 is clear and the programmed select count when set.
- R9: The serial clock stays high for the half-period and has a period of twice the half-period.
- R10: When the last entry completes, the done flag sets and the run bit clears; the flag stays set until the host writes the status register.
- R11: With loop set, the run restarts at the first entry after each pass and the done flag sets on each pass; clearing the run bit stops the controller only after the last entry of the current pass.
- R12: While no transfer is selected the select outputs follow the idle-level register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Host write strobe |
| reg_addr | input | 6 | Host word address |
| reg_wdata | input | 16 | Host write data |
| reg_rdata | output | 16 | Host read data (combinational) |
| spi_din | input | 1 | Serial data from peripherals |
| spi_clk | output | 1 | Serial clock |
| spi_dout | output | 1 | Serial data to peripherals |
| spi_sel_n | output | 4 | Peripheral select levels |

## Verification
A serial peripheral model in the bench logs every output bit with its select levels and time, and returns bits from a fixed 64-bit pattern, so mixed 8-, 12- and 16-bit entries show whether the length field, the bit order and the incoming alignment are each right. A run whose span crosses from entry 15 to 0 separates correct index wrapping from a plain upward count, and untouched entries show nothing outside the span moved. Entries with and without the hold bit and with default versus programmed delays are told apart by counting select releases and measuring the gaps and edge times in clocks. A looping run checks that the flag returns after a clear and that stopping lands on a pass boundary.

// File: rtl/qspi_pkg.sv
package qspi_pkg;

    localparam int WORD_W   = 16;
    localparam int LEN_W    = 5;
    localparam int DLY_W    = 8;
    localparam int SEL_W    = 4;
    localparam int MIN_BITS = 8;

    localparam logic [DLY_W-1:0] DEF_POST = 8'd17;

    // register region codes (upper two address bits)
    localparam logic [1:0] RGN_TX  = 2'd0;
    localparam logic [1:0] RGN_RX  = 2'd1;
    localparam logic [1:0] RGN_CMD = 2'd2;
    localparam logic [1:0] RGN_REG = 2'd3;

    // setup register indices inside RGN_REG
    localparam int RG_CTRL = 0;
    localparam int RG_FMT  = 1;
    localparam int RG_DLY  = 2;
    localparam int RG_IDLE = 3;
    localparam int RG_STAT = 4;

    typedef struct packed {
        logic             hold;     // keep selects into next entry
        logic             use_len;  // programmed length instead of 8
        logic             use_post; // programmed post delay instead of 17
        logic             use_sel;  // programmed select delay instead of half period
        logic [SEL_W-1:0] sel;      // select levels during the transfer
    } cmd_t;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_LOAD,
        ST_SEL,
        ST_HI,
        ST_LO,
        ST_POST
    } seq_st_e;

    function automatic logic [DLY_W-1:0] at_least_one(input logic [DLY_W-1:0] v);
        return (v == '0) ? DLY_W'(1) : v;
    endfunction

    function automatic logic [LEN_W-1:0] xfer_bits(input cmd_t c, input logic [LEN_W-1:0] len);
        if (!c.use_len)
            return LEN_W'(MIN_BITS);
        else if (len < LEN_W'(MIN_BITS))
            return LEN_W'(MIN_BITS);
        else if (len > LEN_W'(WORD_W))
            return LEN_W'(WORD_W);
        else
            return len;
    endfunction

endpackage

// File: rtl/qspi_queue.sv
module qspi_queue #(
    parameter int DEPTH = 16,
    parameter int WIDTH = 16,
    localparam int IW   = $clog2(DEPTH)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             we,
    input  logic [IW-1:0]    waddr,
    input  logic [WIDTH-1:0] wdata,
    input  logic [IW-1:0]    raddr,
    output logic [WIDTH-1:0] rdata
);

    logic [WIDTH-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
        end else if (we) begin
            mem[waddr] <= wdata;
        end
    end

    assign rdata = mem[raddr];

endmodule

// File: rtl/qspi_shifter.sv
module qspi_shifter #(
    parameter int WIDTH = 16,
    localparam int CW   = $clog2(WIDTH + 1)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load,
    input  logic [WIDTH-1:0] load_word,
    input  logic [CW-1:0]    load_bits,
    input  logic             sample,
    input  logic             shift,
    input  logic             din,
    output logic             dout_bit,
    output logic [WIDTH-1:0] rx_word
);

    logic [WIDTH-1:0] tx_sh;
    logic [WIDTH-1:0] rx_sh;

    always_ff @(posedge clk) begin
        if (rst) begin
            tx_sh <= '0;
            rx_sh <= '0;
        end else begin
            if (load) begin
                // left-align the low n bits so the top bit goes first
                tx_sh <= load_word << (WIDTH - int'(load_bits));
                rx_sh <= '0;
            end else begin
                if (shift)  tx_sh <= {tx_sh[WIDTH-2:0], 1'b0};
                if (sample) rx_sh <= {rx_sh[WIDTH-2:0], din};
            end
        end
    end

    assign dout_bit = tx_sh[WIDTH-1];
    assign rx_word  = rx_sh;

endmodule

// File: rtl/qspi_seq.sv
module qspi_seq
    import qspi_pkg::*;
#(
    parameter int DEPTH = 16,
    localparam int IW   = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              en,
    input  logic              wrap,
    input  logic [IW-1:0]     first_idx,
    input  logic [IW-1:0]     last_idx,
    input  logic [LEN_W-1:0]  len,
    input  logic [DLY_W-1:0]  half,
    input  logic [DLY_W-1:0]  post,
    input  logic [DLY_W-1:0]  seldly,
    input  logic [SEL_W-1:0]  idle_sel,
    input  cmd_t              cmd,
    output logic [IW-1:0]     idx,
    output logic              sh_load,
    output logic [LEN_W-1:0]  sh_bits,
    output logic              sh_sample,
    output logic              sh_shift,
    output logic              rx_we,
    output logic              sck,
    output logic              dout_en,
    output logic [SEL_W-1:0]  sel_n,
    output logic              busy,
    output logic              pass_done,
    output logic              run_end
);

    seq_st_e           st;
    logic [DLY_W-1:0]  cnt;
    logic [LEN_W-1:0]  bits_left;
    logic              sel_act;
    logic              cur_hold;
    logic [DLY_W-1:0]  cur_post;
    logic [SEL_W-1:0]  cur_sel;
    logic              sck_q;

    logic              cnt_zero;
    logic              last_entry;
    logic [DLY_W-1:0]  half1;
    logic [DLY_W-1:0]  pre_dly;

    assign cnt_zero   = (cnt == '0);
    assign last_entry = (idx == last_idx);
    assign half1      = at_least_one(half);
    assign pre_dly    = cmd.use_sel ? at_least_one(seldly) : half1;

    assign sh_bits    = xfer_bits(cmd, len);
    assign sh_load    = (st == ST_LOAD);
    assign sh_sample  = cnt_zero && ((st == ST_SEL) || (st == ST_LO && bits_left != '0));
    assign sh_shift   = cnt_zero && (st == ST_HI);
    assign rx_we      = cnt_zero && (st == ST_LO) && (bits_left == '0);
    assign pass_done  = cnt_zero && (st == ST_POST) && last_entry;
    assign run_end    = pass_done && !(wrap && en);

    assign busy       = (st != ST_IDLE);
    assign sck        = sck_q;
    assign dout_en    = (st == ST_SEL) || (st == ST_HI) || (st == ST_LO);
    assign sel_n      = sel_act ? cur_sel : idle_sel;

    always_ff @(posedge clk) begin
        if (rst) begin
            st        <= ST_IDLE;
            idx       <= '0;
            cnt       <= '0;
            bits_left <= '0;
            sel_act   <= 1'b0;
            cur_hold  <= 1'b0;
            cur_post  <= '0;
            cur_sel   <= '1;
            sck_q     <= 1'b0;
        end else begin
            unique case (st)
                ST_IDLE: begin
                    sel_act <= 1'b0;
                    if (en) begin
                        idx <= first_idx;
                        st  <= ST_LOAD;
                    end
                end
                ST_LOAD: begin
                    cur_hold  <= cmd.hold;
                    cur_post  <= cmd.use_post ? at_least_one(post) : DEF_POST;
                    cur_sel   <= cmd.sel;
                    sel_act   <= 1'b1;
                    cnt       <= pre_dly - 1'b1;
                    bits_left <= sh_bits - 1'b1;
                    st        <= ST_SEL;
                end
                ST_SEL: begin
                    if (cnt_zero) begin
                        sck_q <= 1'b1;
                        cnt   <= half1 - 1'b1;
                        st    <= ST_HI;
                    end else begin
                        cnt <= cnt - 1'b1;
                    end
                end
                ST_HI: begin
                    if (cnt_zero) begin
                        sck_q <= 1'b0;
                        cnt   <= half1 - 1'b1;
                        st    <= ST_LO;
                    end else begin
                        cnt <= cnt - 1'b1;
                    end
                end
                ST_LO: begin
                    if (cnt_zero) begin
                        if (bits_left == '0) begin
                            sel_act <= cur_hold;
                            cnt     <= cur_post - 1'b1;
                            st      <= ST_POST;
                        end else begin
                            bits_left <= bits_left - 1'b1;
                            sck_q     <= 1'b1;
                            cnt       <= half1 - 1'b1;
                            st        <= ST_HI;
                        end
                    end else begin
                        cnt <= cnt - 1'b1;
                    end
                end
                ST_POST: begin
                    if (cnt_zero) begin
                        if (last_entry) begin
                            if (wrap && en) begin
                                idx <= first_idx;
                                st  <= ST_LOAD;
                            end else begin
                                sel_act <= 1'b0;
                                st      <= ST_IDLE;
                            end
                        end else begin
                            idx <= idx + 1'b1;
                            st  <= ST_LOAD;
                        end
                    end else begin
                        cnt <= cnt - 1'b1;
                    end
                end
                default: st <= ST_IDLE;
            endcase
        end
    end

endmodule

// File: rtl/qspi_master.sv
module qspi_master
    import qspi_pkg::*;
#(
    parameter int DEPTH = 16,
    localparam int IW   = $clog2(DEPTH)
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               reg_wr,
    input  logic [IW+1:0]      reg_addr,
    input  logic [WORD_W-1:0]  reg_wdata,
    output logic [WORD_W-1:0]  reg_rdata,
    input  logic               spi_din,
    output logic               spi_clk,
    output logic               spi_dout,
    output logic [SEL_W-1:0]   spi_sel_n
);

    localparam int CMD_W = $bits(cmd_t);

    logic [1:0]        rgn;
    logic [IW-1:0]     ridx;
    logic              reg_hit;
    logic              stat_clr;

    logic [IW-1:0]     first_q, last_q;
    logic              wrap_q, en_q;
    logic [LEN_W-1:0]  len_q;
    logic [DLY_W-1:0]  half_q, post_q, seldly_q;
    logic [SEL_W-1:0]  idle_q;
    logic              fin_q;

    logic [IW-1:0]     idx;
    logic [WORD_W-1:0] tx_word, rx_rd, rx_word;
    logic [CMD_W-1:0]  cmd_raw;
    logic              sh_load, sh_sample, sh_shift, rx_we;
    logic [LEN_W-1:0]  sh_bits;
    logic              dout_bit, dout_en;
    logic              busy, pass_done, run_end;

    assign rgn      = reg_addr[IW+1:IW];
    assign ridx     = reg_addr[IW-1:0];
    assign reg_hit  = reg_wr && (rgn == RGN_REG);
    assign stat_clr = reg_hit && (ridx == IW'(RG_STAT));

    // setup registers
    always_ff @(posedge clk) begin
        if (rst) begin
            first_q  <= '0;
            last_q   <= '0;
            wrap_q   <= 1'b0;
            en_q     <= 1'b0;
            len_q    <= LEN_W'(WORD_W);
            half_q   <= DLY_W'(4);
            post_q   <= '0;
            seldly_q <= '0;
            idle_q   <= '1;
            fin_q    <= 1'b0;
        end else begin
            if (run_end) en_q <= 1'b0;
            if (reg_hit) begin
                unique case (int'(ridx))
                    RG_CTRL: begin
                        first_q <= reg_wdata[IW-1:0];
                        last_q  <= reg_wdata[2*IW-1:IW];
                        wrap_q  <= reg_wdata[2*IW];
                        en_q    <= reg_wdata[2*IW+1];
                    end
                    RG_FMT: begin
                        len_q  <= reg_wdata[LEN_W-1:0];
                        half_q <= reg_wdata[15:8];
                    end
                    RG_DLY: begin
                        post_q   <= reg_wdata[7:0];
                        seldly_q <= reg_wdata[15:8];
                    end
                    RG_IDLE: idle_q <= reg_wdata[SEL_W-1:0];
                    default: ;
                endcase
            end
            if (pass_done)     fin_q <= 1'b1;
            else if (stat_clr) fin_q <= 1'b0;
        end
    end

    always_comb begin
        reg_rdata = '0;
        if (rgn == RGN_RX) begin
            reg_rdata = rx_rd;
        end else if (rgn == RGN_REG) begin
            unique case (int'(ridx))
                RG_CTRL: begin
                    reg_rdata[IW-1:0]    = first_q;
                    reg_rdata[2*IW-1:IW] = last_q;
                    reg_rdata[2*IW]      = wrap_q;
                    reg_rdata[2*IW+1]    = en_q;
                end
                RG_FMT: begin
                    reg_rdata[LEN_W-1:0] = len_q;
                    reg_rdata[15:8]      = half_q;
                end
                RG_DLY:  reg_rdata = {seldly_q, post_q};
                RG_IDLE: reg_rdata[SEL_W-1:0] = idle_q;
                RG_STAT: reg_rdata[0] = fin_q;
                default: ;
            endcase
        end
    end

    qspi_queue #(.DEPTH(DEPTH), .WIDTH(WORD_W)) u_txq (
        .clk(clk), .rst(rst),
        .we(reg_wr && rgn == RGN_TX), .waddr(ridx), .wdata(reg_wdata),
        .raddr(idx), .rdata(tx_word)
    );

    qspi_queue #(.DEPTH(DEPTH), .WIDTH(CMD_W)) u_cmdq (
        .clk(clk), .rst(rst),
        .we(reg_wr && rgn == RGN_CMD), .waddr(ridx), .wdata(reg_wdata[CMD_W-1:0]),
        .raddr(idx), .rdata(cmd_raw)
    );

    qspi_queue #(.DEPTH(DEPTH), .WIDTH(WORD_W)) u_rxq (
        .clk(clk), .rst(rst),
        .we(rx_we), .waddr(idx), .wdata(rx_word),
        .raddr(ridx), .rdata(rx_rd)
    );

    qspi_shifter #(.WIDTH(WORD_W)) u_shift (
        .clk(clk), .rst(rst),
        .load(sh_load), .load_word(tx_word), .load_bits(sh_bits),
        .sample(sh_sample), .shift(sh_shift), .din(spi_din),
        .dout_bit(dout_bit), .rx_word(rx_word)
    );

    qspi_seq #(.DEPTH(DEPTH)) u_seq (
        .clk(clk), .rst(rst),
        .en(en_q), .wrap(wrap_q), .first_idx(first_q), .last_idx(last_q),
        .len(len_q), .half(half_q), .post(post_q), .seldly(seldly_q),
        .idle_sel(idle_q), .cmd(cmd_t'(cmd_raw)),
        .idx(idx), .sh_load(sh_load), .sh_bits(sh_bits),
        .sh_sample(sh_sample), .sh_shift(sh_shift), .rx_we(rx_we),
        .sck(spi_clk), .dout_en(dout_en), .sel_n(spi_sel_n),
        .busy(busy), .pass_done(pass_done), .run_end(run_end)
    );

    assign spi_dout = dout_en ? dout_bit : 1'b1;

endmodule

// File: rtl/qspi_master_chk.sv
module qspi_master_chk (
    input logic       clk,
    input logic       rst,
    input logic       spi_clk,
    input logic       spi_dout,
    input logic [3:0] spi_sel_n,
    input logic       busy,
    input logic [3:0] idle_sel,
    input logic       fin,
    input logic       fin_clr
);

    AST_IDLE_BUS_QUIET: assert property (@(posedge clk) disable iff (rst)
        !busy |-> (!spi_clk && spi_dout)) else $error("idle bus not quiet"); // R1

    AST_IDLE_SEL_LEVELS: assert property (@(posedge clk) disable iff (rst)
        !busy |-> (spi_sel_n == idle_sel)) else $error("idle selects wrong"); // R12

    AST_SEL_STABLE_HIGH: assert property (@(posedge clk) disable iff (rst)
        (spi_clk && $past(spi_clk)) |-> $stable(spi_sel_n)) else $error("select moved with clock high"); // R5

    AST_DOUT_STABLE_HIGH: assert property (@(posedge clk) disable iff (rst)
        (spi_clk && $past(spi_clk)) |-> $stable(spi_dout)) else $error("data moved with clock high"); // R3

    AST_DONE_STICKY: assert property (@(posedge clk) disable iff (rst)
        (fin && !fin_clr) |=> fin) else $error("done flag dropped"); // R10

endmodule

bind qspi_master qspi_master_chk u_chk (
    .clk(clk),
    .rst(rst),
    .spi_clk(spi_clk),
    .spi_dout(spi_dout),
    .spi_sel_n(spi_sel_n),
    .busy(busy),
    .idle_sel(idle_q),
    .fin(fin_q),
    .fin_clr(stat_clr)
);

// File: tb/qspi_master_tb.sv
`timescale 1ns/1ps
module qspi_master_tb;

    localparam int AW = 6;
    localparam logic [AW-1:0] A_CTRL = 6'h30, A_FMT = 6'h31, A_DLY = 6'h32,
                              A_IDLE = 6'h33, A_STAT = 6'h34;
    localparam logic [63:0] PAT = 64'hF0E1_D2C3_B4A5_9687;

    logic clk = 1'b0;
    logic rst = 1'b1;
    always #10 clk = ~clk;

    logic          reg_wr = 1'b0;
    logic [AW-1:0] reg_addr = '0;
    logic [15:0]   reg_wdata = '0;
    logic [15:0]   reg_rdata;
    logic          spi_din;
    logic          spi_clk, spi_dout;
    logic [3:0]    spi_sel_n;

    qspi_master u_dut (
        .clk(clk), .rst(rst),
        .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .spi_din(spi_din), .spi_clk(spi_clk), .spi_dout(spi_dout), .spi_sel_n(spi_sel_n)
    );

    int checks = 0;
    int errors = 0;

    // peripheral model and logs
    int     nb = 0, nfl = 0, nf = 0, nr = 0, sbase = 0;
    logic   bitlog [1024];
    logic [3:0] sellog [1024];
    longint rt [1024];
    longint ft [256];
    longint ct [256];
    longint hi_w = 0;
    logic [3:0] sel_prev = 4'hF;

    assign spi_din = PAT[63 - ((nfl - sbase) % 64)];

    always @(posedge spi_clk) begin
        if (nb < 1024) begin
            bitlog[nb] = spi_dout;
            sellog[nb] = spi_sel_n;
            rt[nb]     = $time;
        end
        nb = nb + 1;
    end

    always @(negedge spi_clk) begin
        nfl  = nfl + 1;
        if (nb > 0 && nb <= 1024) hi_w = $time - rt[nb-1];
    end

    always @(spi_sel_n) begin
        if (sel_prev == 4'hF && spi_sel_n != 4'hF && nf < 256) begin ft[nf] = $time; nf = nf + 1; end
        if (sel_prev != 4'hF && spi_sel_n == 4'hF && nr < 256) begin ct[nr] = $time; nr = nr + 1; end
        sel_prev = spi_sel_n;
    end

    task automatic check(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic wr(input logic [AW-1:0] a, input logic [15:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd(input logic [AW-1:0] a, output logic [15:0] d);
        @(negedge clk);
        reg_addr = a;
        #1 d = reg_rdata;
    endtask

    task automatic entry(input int i, input logic [7:0] c, input logic [15:0] t);
        wr(AW'(i), t);
        wr(AW'(32 + i), {8'h00, c});
    endtask

    function automatic logic [15:0] slice(input int o, input int n);
        logic [15:0] w = '0;
        for (int j = 0; j < n; j++) w = {w[14:0], PAT[63 - ((o + j) % 64)]};
        return w;
    endfunction

    function automatic logic [15:0] logword(input int b, input int n);
        logic [15:0] w = '0;
        for (int j = 0; j < n; j++) w = {w[14:0], bitlog[b + j]};
        return w;
    endfunction

    function automatic int cyc(input longint a, input longint b);
        return int'((b - a) / 20);
    endfunction

    task automatic wait_done(input string req);
        logic [15:0] d;
        bit got = 0;
        for (int k = 0; k < 5000 && !got; k++) begin
            rd(A_STAT, d);
            if (d[0]) got = 1;
        end
        check(req, "done flag raised", 32'(got), 32'd1);
    endtask

    task automatic start_run(input int s, input int e, input bit lp);
        wr(A_CTRL, 16'((1 << 9) | (int'(lp) << 8) | (e << 4) | s));
    endtask

    task automatic t_reset();
        logic [15:0] d;
        check("R1", "select idle", 32'(spi_sel_n), 32'hF);
        check("R1", "clock low", 32'(spi_clk), 32'd0);
        check("R1", "data high", 32'(spi_dout), 32'd1);
        rd(A_STAT, d); check("R1", "done clear", 32'(d), 32'd0);
        rd(6'h10, d);  check("R1", "incoming entry 0", 32'(d), 32'd0);
        rd(6'h1F, d);  check("R1", "incoming entry 15", 32'(d), 32'd0);
    endtask

    task automatic t_basic();
        logic [15:0] d;
        int b0, r0;
        entry(0, 8'h0E, 16'h12A5);
        entry(1, 8'h4D, 16'hC33C);
        b0 = nb; r0 = nr; sbase = nfl;
        start_run(0, 1, 0);
        wait_done("R10");
        check("R3", "bit count 8+16", 32'(nb - b0), 32'd24);
        check("R3", "8-bit word", 32'(logword(b0, 8)), 32'hA5);
        check("R3", "16-bit word", 32'(logword(b0 + 8, 16)), 32'hC33C);
        check("R5", "entry 0 selects", 32'(sellog[b0]), 32'hE);
        check("R5", "entry 1 selects", 32'(sellog[b0 + 8]), 32'hD);
        check("R6", "releases without hold", 32'(nr - r0), 32'd2);
        rd(6'h10, d); check("R4", "incoming entry 0", 32'(d), 32'(slice(0, 8)));
        rd(6'h11, d); check("R4", "incoming entry 1", 32'(d), 32'(slice(8, 16)));
        rd(A_CTRL, d); check("R10", "run bit cleared", 32'(d[9]), 32'd0);
        wr(A_STAT, 16'h0);
        rd(A_STAT, d); check("R10", "done cleared by host", 32'(d), 32'd0);
    endtask

    task automatic t_span();
        logic [15:0] d;
        int b0;
        wr(A_FMT, 16'h040C);
        entry(14, 8'h4E, 16'hFABC);
        entry(15, 8'h0E, 16'h0077);
        b0 = nb; sbase = nfl;
        start_run(14, 1, 0);
        wait_done("R2");
        check("R2", "bits over 14,15,0,1", 32'(nb - b0), 32'd40);
        check("R3", "12-bit word", 32'(logword(b0, 12)), 32'hABC);
        check("R2", "entry 15 word", 32'(logword(b0 + 12, 8)), 32'h77);
        check("R2", "entry 0 word", 32'(logword(b0 + 20, 8)), 32'hA5);
        check("R3", "entry 1 12-bit", 32'(logword(b0 + 28, 12)), 32'h33C);
        rd(6'h1E, d); check("R4", "incoming entry 14", 32'(d), 32'(slice(0, 12)));
        rd(6'h1F, d); check("R4", "incoming entry 15", 32'(d), 32'(slice(12, 8)));
        rd(6'h11, d); check("R4", "incoming entry 1", 32'(d), 32'(slice(28, 12)));
        rd(6'h19, d); check("R2", "entry 9 untouched", 32'(d), 32'd0);
        rd(6'h12, d); check("R2", "entry 2 untouched", 32'(d), 32'd0);
        wr(A_STAT, 16'h0);
    endtask

    task automatic t_timing();
        int b0, f0, r0;
        wr(A_FMT, 16'h0310);
        wr(A_DLY, 16'h0705);
        entry(0, 8'h0E, 16'h00FF);
        entry(1, 8'h3E, 16'h0000);
        entry(2, 8'h0E, 16'h0081);
        b0 = nb; f0 = nf; r0 = nr; sbase = nfl;
        start_run(0, 2, 0);
        wait_done("R7");
        check("R8", "default select delay", 32'(cyc(ft[f0], rt[b0])), 32'd3);
        check("R8", "programmed select delay", 32'(cyc(ft[f0 + 1], rt[b0 + 8])), 32'd7);
        check("R7", "default gap", 32'(cyc(ct[r0], ft[f0 + 1])), 32'd18);
        check("R7", "programmed gap", 32'(cyc(ct[r0 + 1], ft[f0 + 2])), 32'd6);
        check("R9", "clock period", 32'(cyc(rt[b0], rt[b0 + 1])), 32'd6);
        check("R9", "clock high width", 32'(hi_w / 20), 32'd3);
        wr(A_STAT, 16'h0);
    endtask

    task automatic t_hold();
        int b0, r0;
        wr(A_FMT, 16'h0210);
        entry(0, 8'h85, 16'h00AA);
        entry(1, 8'h05, 16'h0055);
        b0 = nb; r0 = nr; sbase = nfl;
        start_run(0, 1, 0);
        wait_done("R6");
        check("R6", "single release with hold", 32'(nr - r0), 32'd1);
        check("R6", "held selects on entry 1", 32'(sellog[b0 + 8]), 32'h5);
        check("R3", "held pair data", 32'(logword(b0, 16)), 32'hAA55);
        wr(A_STAT, 16'h0);
    endtask

    task automatic t_loop();
        logic [15:0] d;
        int b0, n1;
        wr(A_FMT, 16'h0110);
        b0 = nb; sbase = nfl;
        start_run(0, 1, 1);
        wait_done("R11");
        wr(A_STAT, 16'h0);
        rd(A_STAT, d); check("R11", "flag cleared mid-loop", 32'(d[0]), 32'd0);
        wait_done("R11");
        rd(A_CTRL, d); check("R11", "still running", 32'(d[9]), 32'd1);
        wr(A_CTRL, 16'h0110);
        repeat (400) @(posedge clk);
        @(negedge clk);
        check("R11", "stopped on pass boundary", 32'((nb - b0) % 16), 32'd0);
        check("R11", "selects idle after stop", 32'(spi_sel_n), 32'hF);
        n1 = nb;
        repeat (100) @(posedge clk);
        @(negedge clk);
        check("R11", "no clocks after stop", 32'(nb), 32'(n1));
        wr(A_STAT, 16'h0);
    endtask

    task automatic t_idle();
        int b0;
        wr(A_IDLE, 16'h0007);
        repeat (2) @(negedge clk);
        check("R12", "idle levels follow register", 32'(spi_sel_n), 32'h7);
        entry(0, 8'h0E, 16'h0011);
        entry(1, 8'h0E, 16'h0022);
        b0 = nb; sbase = nfl;
        start_run(0, 1, 0);
        wait_done("R12");
        check("R5", "selects during transfer", 32'(sellog[b0]), 32'hE);
        check("R12", "idle levels after run", 32'(spi_sel_n), 32'h7);
        wr(A_IDLE, 16'h000F);
        repeat (2) @(negedge clk);
        check("R12", "idle levels restored", 32'(spi_sel_n), 32'hF);
        wr(A_STAT, 16'h0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: run did not complete");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (5) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_basic();
        t_span();
        t_timing();
        t_hold();
        t_loop();
        t_idle();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule